// File: doc/BRIEF.md
# Priming Elastic Bit Buffer

This block carries a serial bit stream from a receive clock, recovered from incoming line data, into a local transmit clock that runs at a slightly different rate. Bits are stored one at a time on the receive side. The transmit side sends nothing until enough bits have built up to absorb clock drift in either direction. From then on it sends one bit on every transmit clock until the stored bits run out at the end of the packet.

A packet is framed by a level input, `wr_env`, which is high while line activity is present. A rising edge starts a new packet. Both pointers then go back to zero and both fault flags are cleared, so priming starts again from an empty store. A falling edge marks the end of the stream, and the transmit side drains whatever is still stored. Pointers cross between the two clocks in Gray code through two-stage synchronizers. The envelope takes one stage more, so that each side sees pointer values that have already settled. The half-depth `HALF` defaults to 12 bits. That covers the roughly 10 bits of drift that a 1000 ppm relative offset builds up over a 9644-bit packet, with a small margin.

Top module: `prime_elastic_buf`

## Requirements
- R1: The store holds CAP = 2^ceil(log2(2*HALF)) bits (32 by default). A write that arrives while the write side counts CAP bits stored is discarded, and `wr_ovf` goes high and stays high until the next packet start.
- R2: `rd_vld` stays low until the read side has counted at least HALF (12) stored bits of the current packet, or has seen the packet end. `rd_primed` is high from that point until the store is drained.
- R3: Every accepted bit leaves on `rd_bit` exactly once and in the order it was written. `rd_vld` is high for one read clock per bit.
- R4: With the read clock 1000 ppm faster or 1000 ppm slower than the write clock, a 9644-bit packet passes complete, with neither `wr_ovf` nor `rd_udf` raised.
- R5: After `wr_env` falls, the read side keeps sending until the last stored bit has left, then drops `rd_primed`. A packet shorter than HALF bits is delivered in full.
- R6: If the read side is draining, `wr_env` is still high and no stored bit is available, no bit is sent in that cycle and `rd_udf` goes high and stays high until the next packet start.
- R7: A rising edge of `wr_env` restarts both pointers from an empty store and clears `wr_ovf` and `rd_udf`.
- R8: While either reset is asserted (active low, asynchronous), the outputs of that side are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write side |
| wr_env | input | 1 | High while a packet is on the line; rising edge starts a packet |
| wr_vld | input | 1 | A bit is present on `wr_bit` this cycle |
| wr_bit | input | 1 | Incoming data bit |
| wr_ovf | output | 1 | Sticky overflow flag (write clock domain) |
| rd_clk | input | 1 | Local transmit clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read side |
| rd_bit | output | 1 | Outgoing data bit |
| rd_vld | output | 1 | `rd_bit` carries a stored bit this cycle |
| rd_primed | output | 1 | Priming reached; the read side is draining |
| rd_udf | output | 1 | Sticky underflow flag (read clock domain) |

## Verification
The bench sends whole packets under several rate ratios and compares the recovered bit sequence with a pattern it computes from the bit index. It also measures how many bits had been written when the first bit came out. A design that primed too early or too late, for example at empty or at full, lands outside the window just above HALF. The two 9644-bit packets at plus and minus 1000 ppm catch a store that is sized or centred too tightly, because that would raise a flag or lose bits. Packets of 5 and 11 bits catch a read side that waits for half-full forever or loses the tail after the envelope drops. Deliberate overflow and underflow runs, each followed by a clean packet, catch flags that fail to set, fail to stick, or survive a restart.

// File: rtl/pebuf_pkg.sv
package pebuf_pkg;

  // Read-side control states.
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,   // no packet in progress
    RD_FILL  = 2'd1,   // packet open, waiting for the priming level
    RD_DRAIN = 2'd2    // one bit out per read clock
  } rd_state_e;

endpackage

// File: rtl/pebuf_sync.sv
// Multi-stage synchronizer for a bus that changes at most one bit per
// source clock (Gray pointer) or for a single level.
module pebuf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pebuf_store.sv
// Bit storage: written on the receive clock, read combinationally by the
// transmit side. A cell is only read once its write is visible through the
// synchronized write pointer, so it is stable when sampled.
module pebuf_store #(
  parameter int AW = 5
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);

  localparam int CAP = 1 << AW;

  logic [CAP-1:0] cells;

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/pebuf_wr_side.sv
// Receive-clock side: write pointer, packet restart, full detection.
module pebuf_wr_side #(
  parameter int HALF = 12,
  parameter int AW   = 5,
  parameter int PW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          env,
  input  logic          vld,
  input  logic          din,
  input  logic [PW-1:0] rd_gray_s,   // read pointer, already synchronized
  output logic [PW-1:0] wr_gray,     // registered Gray write pointer
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          wdata,
  output logic          ovf,
  // events brought out for the checker
  output logic [PW-1:0] occ,
  output logic          drop,
  output logic          restart
);

  localparam int CAP = 1 << AW;
  localparam logic [PW-1:0] CAP_P = PW'(CAP);

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] bin_to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic          env_q;
  logic          aligned;     // the read side has restarted for this packet
  logic [PW-1:0] wptr;
  logic [PW-1:0] base;
  logic [PW-1:0] rptr_seen;
  logic [PW-1:0] wptr_nxt;
  logic          accept;

  assign restart   = env & ~env_q;
  assign rptr_seen = gray_to_bin(rd_gray_s);
  assign base      = restart ? '0 : wptr;

  // Until the reset read pointer has come back across, the stale one is
  // meaningless; counting from zero is then the safe view.
  always_comb begin
    if (restart)      occ = '0;
    else if (aligned) occ = wptr - rptr_seen;
    else              occ = wptr;
  end

  assign drop     = env & vld & (occ >= CAP_P);
  assign accept   = env & vld & ~drop;
  assign wptr_nxt = accept ? base + PW'(1) : base;

  assign we    = accept;
  assign waddr = base[AW-1:0];
  assign wdata = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      env_q   <= 1'b0;
      wptr    <= '0;
      wr_gray <= '0;
      ovf     <= 1'b0;
      aligned <= 1'b1;
    end else begin
      env_q   <= env;
      wptr    <= wptr_nxt;
      wr_gray <= bin_to_gray(wptr_nxt);
      if (restart)   ovf <= 1'b0;
      else if (drop) ovf <= 1'b1;
      if (restart)               aligned <= 1'b0;
      else if (rptr_seen == '0)  aligned <= 1'b1;
    end
  end

endmodule

// File: rtl/pebuf_rd_side.sv
// Transmit-clock side: priming, draining, underflow detection.
module pebuf_rd_side
  import pebuf_pkg::*;
#(
  parameter int HALF = 12,
  parameter int AW   = 5,
  parameter int PW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          env_s,       // envelope, already synchronized
  input  logic [PW-1:0] wr_gray_s,   // write pointer, already synchronized
  input  logic          rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rd_gray,
  output logic          dout,
  output logic          dvld,
  output logic          primed,
  output logic          udf,
  // events brought out for the checker
  output logic [PW-1:0] occ,
  output logic          restart
);

  localparam logic [PW-1:0] HALF_P = PW'(HALF);

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] bin_to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  rd_state_e     state, state_nxt;
  logic          env_q;
  logic [PW-1:0] rptr, rptr_nxt;
  logic          dout_nxt, dvld_nxt, udf_nxt;

  assign restart = env_s & ~env_q;
  assign occ     = gray_to_bin(wr_gray_s) - rptr;
  assign raddr   = rptr[AW-1:0];
  assign primed  = (state == RD_DRAIN);

  always_comb begin
    state_nxt = state;
    rptr_nxt  = rptr;
    dout_nxt  = dout;
    dvld_nxt  = 1'b0;
    udf_nxt   = udf;
    if (restart) begin
      state_nxt = RD_FILL;
      rptr_nxt  = '0;
      udf_nxt   = 1'b0;
    end else begin
      unique case (state)
        RD_FILL: begin
          if (occ >= HALF_P)        state_nxt = RD_DRAIN;
          else if (!env_s)          state_nxt = (occ != '0) ? RD_DRAIN : RD_IDLE;
        end
        RD_DRAIN: begin
          if (occ != '0) begin
            dout_nxt = rdata;
            dvld_nxt = 1'b1;
            rptr_nxt = rptr + PW'(1);
          end else if (env_s) begin
            udf_nxt  = 1'b1;
          end else begin
            state_nxt = RD_IDLE;
          end
        end
        default: state_nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RD_IDLE;
      env_q   <= 1'b0;
      rptr    <= '0;
      rd_gray <= '0;
      dout    <= 1'b0;
      dvld    <= 1'b0;
      udf     <= 1'b0;
    end else begin
      state   <= state_nxt;
      env_q   <= env_s;
      rptr    <= rptr_nxt;
      rd_gray <= bin_to_gray(rptr_nxt);
      dout    <= dout_nxt;
      dvld    <= dvld_nxt;
      udf     <= udf_nxt;
    end
  end

endmodule

// File: rtl/prime_elastic_buf.sv
module prime_elastic_buf #(
  parameter int HALF     = 12,
  parameter int PTR_SYNC = 2
) (
  input  logic wr_clk,
  input  logic wr_rst_n,
  input  logic wr_env,
  input  logic wr_vld,
  input  logic wr_bit,
  output logic wr_ovf,
  input  logic rd_clk,
  input  logic rd_rst_n,
  output logic rd_bit,
  output logic rd_vld,
  output logic rd_primed,
  output logic rd_udf
);

  localparam int AW       = $clog2(2 * HALF);
  localparam int PW       = AW + 1;
  localparam int ENV_SYNC = PTR_SYNC + 1;   // envelope lags pointers by a stage

  logic [PW-1:0] wr_gray_w, wr_gray_rs;
  logic [PW-1:0] rd_gray_w, rd_gray_ws;
  logic [PW-1:0] wr_occ_w, rd_occ_w;
  logic          wr_drop_w, wr_restart_w, rd_restart_w;
  logic          rd_env_s_w;
  logic          st_we, st_wdata, st_rdata;
  logic [AW-1:0] st_waddr, st_raddr;

  pebuf_wr_side #(.HALF(HALF), .AW(AW), .PW(PW)) u_wr (
    .clk       (wr_clk),
    .rst_n     (wr_rst_n),
    .env       (wr_env),
    .vld       (wr_vld),
    .din       (wr_bit),
    .rd_gray_s (rd_gray_ws),
    .wr_gray   (wr_gray_w),
    .we        (st_we),
    .waddr     (st_waddr),
    .wdata     (st_wdata),
    .ovf       (wr_ovf),
    .occ       (wr_occ_w),
    .drop      (wr_drop_w),
    .restart   (wr_restart_w)
  );

  pebuf_store #(.AW(AW)) u_store (
    .wr_clk (wr_clk),
    .we     (st_we),
    .waddr  (st_waddr),
    .wdata  (st_wdata),
    .raddr  (st_raddr),
    .rdata  (st_rdata)
  );

  pebuf_sync #(.W(PW), .STAGES(PTR_SYNC)) u_sync_w2r (
    .clk (rd_clk), .rst_n (rd_rst_n), .d (wr_gray_w), .q (wr_gray_rs)
  );

  pebuf_sync #(.W(1), .STAGES(ENV_SYNC)) u_sync_env (
    .clk (rd_clk), .rst_n (rd_rst_n), .d (wr_env), .q (rd_env_s_w)
  );

  pebuf_sync #(.W(PW), .STAGES(PTR_SYNC)) u_sync_r2w (
    .clk (wr_clk), .rst_n (wr_rst_n), .d (rd_gray_w), .q (rd_gray_ws)
  );

  pebuf_rd_side #(.HALF(HALF), .AW(AW), .PW(PW)) u_rd (
    .clk       (rd_clk),
    .rst_n     (rd_rst_n),
    .env_s     (rd_env_s_w),
    .wr_gray_s (wr_gray_rs),
    .rdata     (st_rdata),
    .raddr     (st_raddr),
    .rd_gray   (rd_gray_w),
    .dout      (rd_bit),
    .dvld      (rd_vld),
    .primed    (rd_primed),
    .udf       (rd_udf),
    .occ       (rd_occ_w),
    .restart   (rd_restart_w)
  );

endmodule

// File: rtl/pebuf_chk.sv
module pebuf_chk #(
  parameter int HALF = 12
) (
  input logic                              wr_clk,
  input logic                              wr_rst_n,
  input logic                              wr_restart,
  input logic                              wr_drop,
  input logic                              wr_ovf,
  input logic [$clog2(2*HALF):0]           wr_occ,
  input logic [$clog2(2*HALF):0]           wr_gray,
  input logic                              rd_clk,
  input logic                              rd_rst_n,
  input logic                              rd_restart,
  input logic                              rd_env_s,
  input logic [$clog2(2*HALF):0]           rd_occ,
  input logic [$clog2(2*HALF):0]           rd_gray,
  input logic                              rd_primed,
  input logic                              rd_vld,
  input logic                              rd_udf
);

  localparam int AW = $clog2(2 * HALF);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] HALF_P = PW'(HALF);
  localparam logic [PW-1:0] CAP_P  = PW'(1 << AW);

  AST_DROP_SETS_OVF: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_drop |=> wr_ovf);                                                        // R1
  AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_ovf && !wr_restart) |=> wr_ovf);                                        // R1
  AST_WR_OCC_BOUND: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_occ <= CAP_P);                                                           // R1
  AST_PRIME_AT_HALF: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $rose(rd_primed) |-> ($past(rd_occ) >= HALF_P || !$past(rd_env_s)));       // R2
  AST_VLD_NEEDS_PRIMED: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_vld |-> $past(rd_primed));                                               // R2
  AST_UDF_STICKY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_udf && !rd_restart) |=> rd_udf);                                        // R6
  AST_RESTART_CLEARS_UDF: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_restart |=> !rd_udf);                                                    // R7
  AST_WPTR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !wr_restart |=> $countones(wr_gray ^ $past(wr_gray)) <= 1);                 // R7
  AST_RPTR_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_restart |=> $countones(rd_gray ^ $past(rd_gray)) <= 1);                 // R7

endmodule

bind prime_elastic_buf pebuf_chk #(.HALF(HALF)) u_chk (
  .wr_clk     (wr_clk),
  .wr_rst_n   (wr_rst_n),
  .wr_restart (wr_restart_w),
  .wr_drop    (wr_drop_w),
  .wr_ovf     (wr_ovf),
  .wr_occ     (wr_occ_w),
  .wr_gray    (wr_gray_w),
  .rd_clk     (rd_clk),
  .rd_rst_n   (rd_rst_n),
  .rd_restart (rd_restart_w),
  .rd_env_s   (rd_env_s_w),
  .rd_occ     (rd_occ_w),
  .rd_gray    (rd_gray_w),
  .rd_primed  (rd_primed),
  .rd_vld     (rd_vld),
  .rd_udf     (rd_udf)
);

// File: tb/prime_elastic_buf_tb.sv
`timescale 1ps/1ps
module prime_elastic_buf_tb;

  localparam int HALF   = 12;
  localparam int WR_HALF = 4000;     // 125 MHz write clock

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic wr_env = 1'b0, wr_vld = 1'b0, wr_bit = 1'b0;
  logic wr_ovf, rd_bit, rd_vld, rd_primed, rd_udf;
  int   rd_half = WR_HALF;

  prime_elastic_buf #(.HALF(HALF)) u_dut (
    .wr_clk (wr_clk), .wr_rst_n (wr_rst_n), .wr_env (wr_env),
    .wr_vld (wr_vld), .wr_bit (wr_bit), .wr_ovf (wr_ovf),
    .rd_clk (rd_clk), .rd_rst_n (rd_rst_n), .rd_bit (rd_bit),
    .rd_vld (rd_vld), .rd_primed (rd_primed), .rd_udf (rd_udf)
  );

  always #(WR_HALF) wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  int n_chk = 0, n_err = 0;
  int pkt_id = 0, mon_id = 0, cur_seed = 0, wr_cnt = 0;
  int rx_cnt = 0, rx_err = 0, first_wcnt = -1;

  // Bit pattern as a function of position: seed 0 is alternating J/K.
  function automatic logic pat(input int seed, input int i);
    int v;
    if (seed == 0) return i[0];
    v = (i * seed) ^ (i >> 2) ^ (i >> 5);
    return v[0] ^ v[3];
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Read-side monitor, sampled on the falling read edge.
  always @(negedge rd_clk) begin
    if (mon_id != pkt_id) begin
      mon_id = pkt_id; rx_cnt = 0; rx_err = 0; first_wcnt = -1;
    end
    if (rd_vld) begin
      if (first_wcnt < 0) first_wcnt = wr_cnt;
      if (rd_bit !== pat(cur_seed, rx_cnt)) rx_err++;
      rx_cnt++;
    end
  end

  task automatic send(input int len, input int seed, input int rhalf);
    int n;
    rd_half  = rhalf;
    cur_seed = seed;
    wr_cnt   = 0;
    pkt_id++;
    repeat (4) @(negedge wr_clk);
    wr_env = 1'b1;
    for (int i = 0; i < len; i++) begin
      wr_vld = 1'b1;
      wr_bit = pat(seed, i);
      wr_cnt++;
      @(negedge wr_clk);
    end
    wr_vld = 1'b0;
    wr_env = 1'b0;
    repeat (16) @(negedge wr_clk);
    n = 0;
    while (rd_primed && n < 4000) begin
      @(negedge wr_clk);
      n++;
    end
    chk(n < 4000, "R5", "drain completes", n, 0);
    repeat (12) @(negedge wr_clk);
  endtask

  task automatic chk_delivery(input string req, input int len);
    chk(rx_cnt == len, req, "bits delivered", rx_cnt, len);
    chk(rx_err == 0, req, "order mismatches", rx_err, 0);
  endtask

  task automatic chk_prime();
    chk(first_wcnt >= HALF && first_wcnt <= HALF + 8, "R2",
        "bits written at first output", first_wcnt, HALF + 4);
  endtask

  initial begin : watchdog
    #(64'd1_400_000_000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    #10001;
    // R8: reset values while both resets are held
    chk(rd_vld == 1'b0, "R8", "rd_vld in reset", int'(rd_vld), 0);
    chk(rd_primed == 1'b0, "R8", "rd_primed in reset", int'(rd_primed), 0);
    chk(wr_ovf == 1'b0, "R8", "wr_ovf in reset", int'(wr_ovf), 0);
    chk(rd_udf == 1'b0, "R8", "rd_udf in reset", int'(rd_udf), 0);
    #11001;
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;

    // R3: nominal rate, two patterns
    send(300, 1, WR_HALF);
    chk_delivery("R3", 300);
    chk_prime();
    chk(wr_ovf == 1'b0, "R1", "no overflow at equal rates", int'(wr_ovf), 0);
    chk(rd_udf == 1'b0, "R6", "no underflow at equal rates", int'(rd_udf), 0);
    send(120, 0, WR_HALF);
    chk_delivery("R3", 120);

    // R5: packets shorter than HALF
    send(5, 3, WR_HALF);
    chk_delivery("R5", 5);
    send(HALF - 1, 0, WR_HALF);
    chk_delivery("R5", HALF - 1);
    chk(rd_primed == 1'b0, "R5", "primed drops after drain", int'(rd_primed), 0);

    // R4: maximum packet, read clock 1000 ppm slower then faster
    send(9644, 5, 4004);
    chk_delivery("R4", 9644);
    chk_prime();
    chk(wr_ovf == 1'b0, "R4", "slow reader overflow", int'(wr_ovf), 0);
    chk(rd_udf == 1'b0, "R4", "slow reader underflow", int'(rd_udf), 0);
    send(9644, 11, 3996);
    chk_delivery("R4", 9644);
    chk_prime();
    chk(wr_ovf == 1'b0, "R4", "fast reader overflow", int'(wr_ovf), 0);
    chk(rd_udf == 1'b0, "R4", "fast reader underflow", int'(rd_udf), 0);

    // R1: reader at half rate must overflow
    send(100, 7, 2 * WR_HALF);
    chk(wr_ovf == 1'b1, "R1", "overflow with half-rate reader", int'(wr_ovf), 1);
    // R7: next packet clears it
    send(40, 9, WR_HALF);
    chk(wr_ovf == 1'b0, "R7", "overflow cleared by restart", int'(wr_ovf), 0);
    chk_delivery("R7", 40);

    // R6: reader at double rate must underflow
    send(200, 13, WR_HALF / 2);
    chk(rd_udf == 1'b1, "R6", "underflow with double-rate reader", int'(rd_udf), 1);
    send(50, 0, WR_HALF);
    chk(rd_udf == 1'b0, "R7", "underflow cleared by restart", int'(rd_udf), 0);
    chk_delivery("R7", 50);
    chk_prime();

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule